// File: doc/BRIEF.md
# Oversampling Serial Receiver with Ready-to-Send Output

This block receives asynchronous serial words of eight data bits. Each bit lasts sixteen sub-bit ticks, and a programmable divisor sets the length of one tick. The receiver waits on an idle-high line. A falling edge on that line restarts all bit timing. The start bit is then tested at its midpoint, so a short glitch sends the receiver back to idle. After that, the data bits are shifted in least significant bit first. An optional parity bit is checked, and the stop bit is checked last.

When the stop bit is sampled, the word moves to a holding buffer and three things are raised: a completion flag, an interrupt request and error status. A ready-to-send output tells the far end to pause. It goes high once a start bit is accepted and stays high until software reads the buffer, so the sender is held off while an unread word sits in the buffer. The interrupt is cleared by an acknowledge strobe. A buffer read clears the completion and overrun flags.

Top module: `uart_rx_os`

## Requirements
- R1: A word is received only while `rx_en` is 1. While `rx_en` is 0, the receiver stays idle and activity on `rxd` changes no output.
- R2: After a falling edge on `rxd`, the line is sampled at the start bit's midpoint. If it reads high, the receiver returns to idle: no word is stored and `rts` stays low.
- R3: A bit lasts 16·(`divisor`+1) clock cycles and is sampled at its 8th tick. The frame is a start bit (0), then D0..D7 least significant bit first, then an optional parity bit, then a stop bit (1).
- R4: When the stop bit is sampled, the shifted word appears on `rx_data` and `rx_done` becomes 1.
- R5: `irq` becomes 1 when a word is stored and stays 1 until `irq_ack` is pulsed.
- R6: With `parity_en`=1, a parity bit follows D7. `parity_odd`=0 selects even parity and 1 selects odd parity. If the parity bit does not match, `err_parity` is 1 for that word.
- R7: A stop bit sampled low sets `err_frame` for that word. The word is still stored.
- R8: If a word is stored while `rx_done` is already 1, `err_overrun` is set and `rx_data` takes the new word.
- R9: A `rd_strobe` pulse clears `rx_done` and `err_overrun`.
- R10: `rts` is 1 while `rx_en` is 0. While enabled, it rises when a start bit is accepted, stays 1 until the next `rd_strobe`, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line, idle high |
| divisor | input | DIV_W | Tick length minus one, in clocks |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_strobe | input | 1 | Buffer read pulse |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| rx_data | output | 8 | Received word buffer |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Interrupt request |
| rts | output | 1 | Ready-to-send, high blocks sender |
| err_frame | output | 1 | Stop bit read low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Unread word overwritten |

## Verification
A falling edge on `rxd` takes effect three clocks later: two synchronizer stages plus the edge register. Each sample then comes (8+16k)·(`divisor`+1) clocks after that point. The stored word, its flags and `irq` are therefore due at the midpoint of the stop bit, half a bit before the bench finishes driving the frame. The bench checks them only after the whole frame, plus two clocks, has been driven. Read and acknowledge strobes act on the next edge, and their effects are checked one clock later.

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] divisor,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             rd_strobe,
  input  logic             irq_ack,
  output logic [7:0]       rx_data,
  output logic             rx_done,
  output logic             irq,
  output logic             rts,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             state;
  logic [1:0]      sync;
  logic            prev;
  logic [DIV_W-1:0] pre;
  logic [3:0]      tcnt;
  logic [2:0]      bitcnt;
  logic [7:0]      sh;
  logic            pbad;
  logic            hold;

  wire rxd_s = sync[1];
  wire tick  = (pre == divisor);
  wire samp  = tick && (tcnt == 4'd7) && (state != S_IDLE);
  wire fall  = prev && !rxd_s;
  wire xfer  = rx_en && samp && (state == S_STOP);
  wire accept = rx_en && samp && (state == S_START) && !rxd_s;

  assign rts = !rx_en || hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      prev <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      prev <= rxd_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (state == S_IDLE) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (tick) begin
      pre  <= '0;
      tcnt <= tcnt + 4'd1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      pbad   <= 1'b0;
    end else if (!rx_en) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (fall) state <= S_START;
        S_START: if (samp) begin
          state  <= rxd_s ? S_IDLE : S_DATA;
          bitcnt <= '0;
          pbad   <= 1'b0;
        end
        S_DATA: if (samp) begin
          sh     <= {rxd_s, sh[7:1]};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) state <= parity_en ? S_PAR : S_STOP;
        end
        S_PAR: if (samp) begin
          pbad  <= (^sh) ^ rxd_s ^ parity_odd;
          state <= S_STOP;
        end
        S_STOP: if (samp) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_done     <= 1'b0;
      irq         <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      hold        <= 1'b0;
    end else begin
      if (xfer) begin
        rx_data    <= sh;
        err_frame  <= !rxd_s;
        err_parity <= pbad;
      end
      if (xfer)           rx_done <= 1'b1;
      else if (rd_strobe) rx_done <= 1'b0;
      if (xfer && rx_done) err_overrun <= 1'b1;
      else if (rd_strobe)  err_overrun <= 1'b0;
      if (xfer)         irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (accept)         hold <= 1'b1;
      else if (rd_strobe) hold <= 1'b0;
    end
  end

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state == S_IDLE);
  assert_reject_high_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && samp && state == S_START && rxd_s) |=> (state == S_IDLE && $stable(hold)));
  assert_irq_with_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> irq);
  assert_overrun_on_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && rx_done) |=> err_overrun);
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !xfer) |=> (!rx_done && !err_overrun));
  assert_rts_while_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state == S_DATA) |-> rts);

endmodule

// File: tb/tb_uart_rx_os.sv
module tb_uart_rx_os;
  logic clk = 0, rst_n = 0, rx_en = 0, rxd = 1;
  logic [7:0] divisor = 0;
  logic parity_en = 0, parity_odd = 0, rd_strobe = 0, irq_ack = 0;
  logic [7:0] rx_data;
  logic rx_done, irq, rts, err_frame, err_parity, err_overrun;
  int nchk = 0, nfail = 0;

  uart_rx_os #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .divisor(divisor),
    .parity_en(parity_en), .parity_odd(parity_odd), .rd_strobe(rd_strobe),
    .irq_ack(irq_ack), .rx_data(rx_data), .rx_done(rx_done), .irq(irq),
    .rts(rts), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (16 * (int'(divisor) + 1)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (parity_en) drive_bit((^d) ^ parity_odd ^ bad_par);
    drive_bit(!bad_stop);
    rxd = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd();
    rd_strobe = 1; @(negedge clk); rd_strobe = 0; @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("reset rx_done", rx_done, 0);
    chk("reset irq", irq, 0);
    chk("reset errors", {err_frame, err_parity, err_overrun}, 0);
    chk("R10 rts while disabled", rts, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    send(8'h5A, 0, 0);
    chk("R1 disabled ignores line", rx_done, 0);
    chk("R1 disabled no irq", irq, 0);
    rx_en = 1;
    repeat (4) @(negedge clk);
    chk("R10 rts low when free", rts, 0);

    foreach (divisor_set[di]) begin
      divisor = divisor_set[di];
      for (int pm = 0; pm < 3; pm++) begin
        parity_en = (pm != 0);
        parity_odd = (pm == 2);
        for (int k = 0; k < 8; k++) begin
          d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 37 + di * 11 + pm * 5);
          send(d, 0, 0);
          chk("R3 R4 data", rx_data, d);
          chk("R4 rx_done", rx_done, 1);
          chk("R5 irq set", irq, 1);
          chk("R6 no parity error", err_parity, 0);
          chk("R7 no framing error", err_frame, 0);
          chk("R10 rts held", rts, 1);
          rd();
          chk("R9 read clears done", rx_done, 0);
          chk("R10 rts released", rts, 0);
          ack();
          chk("R5 ack clears irq", irq, 0);
        end
      end
    end

    divisor = 1; parity_en = 1; parity_odd = 0;
    send(8'h3C, 1, 0);
    chk("R6 even parity mismatch", err_parity, 1);
    chk("R6 data kept", rx_data, 8'h3C);
    rd(); ack();
    parity_odd = 1;
    send(8'h81, 1, 0);
    chk("R6 odd parity mismatch", err_parity, 1);
    rd(); ack();
    parity_en = 0;
    send(8'hC3, 0, 1);
    chk("R7 framing error", err_frame, 1);
    chk("R7 word stored", rx_data, 8'hC3);
    rd(); ack();
    repeat (40) @(negedge clk);

    rxd = 0; repeat (4 * 2) @(negedge clk); rxd = 1;
    repeat (64) @(negedge clk);
    chk("R2 glitch no word", rx_done, 0);
    chk("R2 glitch rts low", rts, 0);
    send(8'h96, 0, 0);
    chk("R2 after glitch receives", rx_data, 8'h96);
    rd(); ack();

    send(8'h11, 0, 0);
    chk("R8 first no overrun", err_overrun, 0);
    send(8'h22, 0, 0);
    chk("R8 overrun set", err_overrun, 1);
    chk("R8 overwritten", rx_data, 8'h22);
    rd();
    chk("R9 read clears overrun", err_overrun, 0);
    chk("R9 read clears done", rx_done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  logic [7:0] divisor_set [3] = '{8'd0, 8'd1, 8'd3};
endmodule